// File: doc/BRIEF.md
# Cascadable Parity Generator and Checker

The block computes odd parity over a wide data word. The word is built from a chain of nine-input parity stages. The chain shares one bidirectional parity line with a bus, and a single mode input decides what the block does with that line.

In generate mode the block drives the line with the parity bit of the final stage. In check mode it releases the line, reads it back, and pulls an active-low error flag when the final stage's nine inputs and the line together break the odd-ones rule. A registered copy of the flag is also provided. It helps when the flag has to be sampled on a clock edge.

A synchronous power-good qualifier gates the line driver. Until power-good has been sampled high, the line stays released and the error flag stays inactive, so the bus sees no glitch while supplies ramp up or down. Each stage below the last works as a generator. Its parity bit feeds lane 0 of the next stage, so the chain behaves like several single-stage parts wired in cascade.

Top module: `parity_chain`

## Requirements
- R1: After reset, and while the power-good input has not been sampled high on a rising clock edge, `lineOe` is 0 and `errN` is 1 in both modes.
- R2: When power-good is sampled low on a rising edge, `lineOe` is 0 and `errN` is 1 from that edge on, whatever the other inputs are.
- R3: In generate mode (`checkMode`=0) with power qualified, `lineOe` is 1. `lineOut` is 1 when the final stage's nine inputs hold an even number of ones (0, 2, 4, 6 or 8) and 0 when they hold an odd number.
- R4: In generate mode `errN` stays 1 for every data and line value.
- R5: In check mode (`checkMode`=1) `lineOe` is 0, so the line is only read.
- R6: In check mode with power qualified, `errN` is 0 exactly when the final stage's nine inputs plus `lineIn` hold an even number of ones. This happens when an even input count meets `lineIn`=0, or an odd input count meets `lineIn`=1.
- R7: Stage 0 takes `dataIn[8:0]`. Stage k (k≥1) takes the parity bit of stage k-1 on its lane 0 and `dataIn[9+8(k-1) +: 8]` on lanes 1 to 8. Each stage's parity bit is 1 when its nine inputs hold an even count of ones. The final stage's bit is the one used on the line.
- R8: `errQN` equals the value `errN` had at the previous rising clock edge, and it resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the power-good sampler and the registered flag |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Power-good qualifier, sampled on the rising edge |
| checkMode | input | 1 | 0 = generate (drive line), 1 = check (read line) |
| dataIn | input | 9+8·(STAGES-1) | Data word across all cascaded stages |
| lineIn | input | 1 | Sampled value of the shared parity line |
| lineOut | output | 1 | Parity value offered to the shared line |
| lineOe | output | 1 | Drive enable for the shared line |
| errN | output | 1 | Active-low parity error flag, combinational |
| errQN | output | 1 | Active-low parity error flag, registered |

## Verification
The case hardest to reach is a single-bit fault deep in the cascade. A flipped bit in stage 0 must ripple through every later stage before it reaches the line or the error flag. Random words seldom isolate that path. The stimulus therefore walks a single one across every data bit in both modes, and it pairs each word with both line values. It also toggles power-good around mode changes, so that the one-cycle lag of the qualifier meets each mode.

// File: rtl/parity_chain_pkg.sv
package parity_chain_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic drive;  // offer parity on the shared line
    logic judge;  // compare the line against local parity
  } strobe_t;

  function automatic int unsigned chainWidth(int unsigned lanes, int unsigned stages);
    return lanes + (lanes - 1) * (stages - 1);
  endfunction

endpackage

// File: rtl/parity_stage.sv
module parity_stage #(
  parameter int unsigned LANES = 9
) (
  input  logic [LANES-1:0] bits,
  output logic             even
);
  // High when an even count of lanes are set (odd-parity bit).
  assign even = ~(^bits);
endmodule

// File: rtl/parity_ctrl.sv
module parity_ctrl
  import parity_chain_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pwrGood,
  input  logic    checkMode,
  output strobe_t strobe
);
  logic pwrOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwrOk <= 1'b0;
    else       pwrOk <= pwrGood;
  end

  always_comb begin
    strobe.drive = pwrOk & ~checkMode;
    strobe.judge = pwrOk & checkMode;
  end
endmodule

// File: rtl/parity_datapath.sv
module parity_datapath
  import parity_chain_pkg::*;
#(
  parameter int unsigned LANES  = 9,
  parameter int unsigned STAGES = 3,
  localparam int unsigned DATA_W = LANES + (LANES - 1) * (STAGES - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              lineIn,
  output logic              lineOut,
  output logic              lineOe,
  output logic              errN,
  output logic              errQN
);
  logic [LANES-1:0]  stageIn [STAGES];
  logic [STAGES-1:0] stageEven;
  logic              mismatch;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stageIn[g] = dataIn[LANES-1:0];
    end else begin : g_link
      assign stageIn[g] = {dataIn[LANES + (LANES-1)*(g-1) +: LANES-1], stageEven[g-1]};
    end
    parity_stage #(.LANES(LANES)) u_stage (
      .bits (stageIn[g]),
      .even (stageEven[g])
    );
  end

  assign lineOut  = stageEven[STAGES-1];
  assign lineOe   = strobe.drive;
  // Ten bits with an even number of ones break the odd rule.
  assign mismatch = ~(^{stageIn[STAGES-1], lineIn});
  assign errN     = ~(strobe.judge & mismatch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQN <= 1'b1;
    else       errQN <= errN;
  end
endmodule

// File: rtl/parity_chain.sv
module parity_chain
  import parity_chain_pkg::*;
#(
  parameter int unsigned LANES  = 9,
  parameter int unsigned STAGES = 3,
  localparam int unsigned DATA_W = LANES + (LANES - 1) * (STAGES - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic              checkMode,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              lineIn,
  output logic              lineOut,
  output logic              lineOe,
  output logic              errN,
  output logic              errQN
);
  strobe_t strobe;

  parity_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pwrGood   (pwrGood),
    .checkMode (checkMode),
    .strobe    (strobe)
  );

  parity_datapath #(.LANES(LANES), .STAGES(STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .lineIn  (lineIn),
    .lineOut (lineOut),
    .lineOe  (lineOe),
    .errN    (errN),
    .errQN   (errQN)
  );
endmodule

// File: rtl/parity_chain_chk.sv
module parity_chain_chk #(
  parameter int unsigned LANES  = 9,
  parameter int unsigned STAGES = 3,
  localparam int unsigned DATA_W = LANES + (LANES - 1) * (STAGES - 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwrGood,
  input logic              checkMode,
  input logic [DATA_W-1:0] dataIn,
  input logic              lineIn,
  input logic              lineOut,
  input logic              lineOe,
  input logic              errN,
  input logic              errQN
);
  // With a chain of STAGES stages the line bit equals XOR of the word, inverted for odd STAGES.
  localparam logic FLIP = 1'(STAGES % 2);

  p_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pwrGood) |-> (!lineOe && errN));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrGood) |=> (!lineOe && errN));

  p_gen_parity_r3: assert property (@(posedge clk) disable iff (!rstN)
    lineOe |-> (lineOut == ((^dataIn) ^ FLIP)));

  p_gen_noerr_r4: assert property (@(posedge clk) disable iff (!rstN)
    !checkMode |-> errN);

  p_check_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    checkMode |-> !lineOe);

  p_check_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    (checkMode && $past(pwrGood)) |-> (errN == (lineIn == ((^dataIn) ^ FLIP))));

  p_errreg_r8: assert property (@(posedge clk) disable iff (!rstN)
    errQN == $past(errN));
endmodule

bind parity_chain parity_chain_chk #(.LANES(LANES), .STAGES(STAGES)) u_chk (
  .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .checkMode(checkMode),
  .dataIn(dataIn), .lineIn(lineIn), .lineOut(lineOut), .lineOe(lineOe),
  .errN(errN), .errQN(errQN)
);

// File: tb/parity_chain_tb.sv
module parity_chain_tb;
  localparam int unsigned LANES  = 9;
  localparam int unsigned STAGES = 3;
  localparam int unsigned DATA_W = LANES + (LANES - 1) * (STAGES - 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              pwrGood = 1'b0;
  logic              checkMode = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic              lineIn = 1'b0;
  logic              lineOut, lineOe, errN, errQN;

  int errors = 0;
  int checks = 0;
  logic expPg = 1'b0;
  logic expErrNow = 1'b1;

  always #2.5 clk = ~clk;

  parity_chain #(.LANES(LANES), .STAGES(STAGES)) u_dut (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .checkMode(checkMode),
    .dataIn(dataIn), .lineIn(lineIn), .lineOut(lineOut), .lineOe(lineOe),
    .errN(errN), .errQN(errQN)
  );

  // Final-stage parity bit, rebuilt stage by stage from the wiring rule (R7).
  function automatic logic chainParity(logic [DATA_W-1:0] d);
    logic p = 1'b0;
    for (int s = 0; s < STAGES; s++) begin
      logic [LANES-1:0] in;
      if (s == 0) in = d[LANES-1:0];
      else        in = {d[LANES + (LANES-1)*(s-1) +: LANES-1], p};
      p = 1'b1;
      for (int b = 0; b < LANES; b++) if (in[b]) p = ~p;
    end
    return p;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // One clock cycle: drive after falling edge, check, then check the register after the rising edge.
  task automatic runCycle(logic pg, logic mode, logic [DATA_W-1:0] d, logic line);
    logic par;
    @(negedge clk);
    pwrGood = pg; checkMode = mode; dataIn = d; lineIn = line;
    #1;
    par = chainParity(d);
    if (!expPg) begin
      chk("R1/R2 lineOe released", lineOe, 1'b0);
      chk("R1/R2 errN inactive", errN, 1'b1);
    end else if (!mode) begin
      chk("R3 lineOe driven", lineOe, 1'b1);
      chk("R3/R7 lineOut parity", lineOut, par);
      chk("R4 errN in generate", errN, 1'b1);
    end else begin
      chk("R5 lineOe in check", lineOe, 1'b0);
      chk("R6/R7 errN in check", errN, (line == par));
    end
    expErrNow = expPg ? (!mode || (line == par)) : 1'b1;
    @(posedge clk);
    #1;
    expPg = rstN ? pg : 1'b0;
    chk("R8 errQN registered", errQN, expErrNow);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0286));
    repeat (3) @(posedge clk);
    #1;
    chk("R8 errQN reset", errQN, 1'b1);
    chk("R1 lineOe reset", lineOe, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    // Power not yet good: both modes stay quiet (R1).
    runCycle(1'b0, 1'b0, '0, 1'b0);
    runCycle(1'b0, 1'b1, '0, 1'b0);
    // Raise power-good; this cycle still quiet, next one live.
    runCycle(1'b1, 1'b1, '0, 1'b0);
    runCycle(1'b1, 1'b0, '0, 1'b0);
    runCycle(1'b1, 1'b0, '1, 1'b1);
    runCycle(1'b1, 1'b1, '1, 1'b0);
    runCycle(1'b1, 1'b1, '1, 1'b1);
    // Walking one across every lane of every stage (R7), both modes and line values.
    for (int b = 0; b < DATA_W; b++) begin
      runCycle(1'b1, 1'b0, DATA_W'(1) << b, 1'b0);
      runCycle(1'b1, 1'b1, DATA_W'(1) << b, 1'b0);
      runCycle(1'b1, 1'b1, DATA_W'(1) << b, 1'b1);
    end
    // Power drops: released from the next edge on (R2).
    runCycle(1'b0, 1'b0, 25'h0AB_CDEF, 1'b1);
    runCycle(1'b0, 1'b1, 25'h0AB_CDEF, 1'b0);
    runCycle(1'b1, 1'b0, 25'h155_5555, 1'b0);
    // Random mix.
    for (int i = 0; i < 600; i++) begin
      logic pg;
      pg = ($urandom % 8) != 0;
      runCycle(pg, 1'($urandom), DATA_W'({$urandom, $urandom}), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule